// File: doc/BRIEF.md
# Dual-Processor Byte Mailbox Bridge

This block passes bytes between an 8-bit host processor and a 16-bit coprocessor through one shared 8-bit latch. The host reaches the bridge through two I/O registers, a status/control register and a data register, decoded on the low address byte only. The coprocessor reaches the same latch through a small register window. Two handshake flags, readable by the host, record whether the host has taken the coprocessor's byte (receive flag) and whether the host has left a byte for the coprocessor (transmit flag). Accesses from either side move these flags.

Two active-low handshake lines go to the coprocessor. A host data read pulls the acknowledge line low. A host data write pulls the strobe line low. The coprocessor can force either line high or low through an offset-decoded clear/set window. The coprocessor also owns an 8-bit interrupt enable register. Bit 0 of that register gates an interrupt request that is raised while the strobe line is low, and the request carries a fixed vector. The host holds the coprocessor in reset through bit 0 of its control register.

All accesses are single-cycle strobes (chip select with read and/or write). Read data is registered and appears on the cycle after the strobe. If both sides act in the same cycle, the coprocessor's access takes effect first and the host's second.

Top module: `byte_mailbox_bridge`

## Requirements
- R1: During and after reset, cp_reset is 1, cp_ack_n and cp_stb_n are 1, cp_irq is 0 and cp_irq_vec is 0x00. The latch, both flags and the interrupt enable register read back 0.
- R2: Host accesses decode only h_addr[7:0]: 0xB8 selects status/control and 0xB9 selects data, whatever the upper address bits are. A host read at any other address returns 0x00, and a host write there changes nothing.
- R3: A host status read returns 0xF0 | (tx_flag << 1) | rx_flag, so bits 3:2 are 0.
- R4: A host data read returns the latch, sets the receive flag and drives cp_ack_n low.
- R5: A host data write loads the latch, sets the transmit flag and drives cp_stb_n low.
- R6: A coprocessor write at c_addr 0 loads the latch and clears the receive flag. A coprocessor read at c_addr 0 returns the latch and clears the transmit flag.
- R7: A host control write sets cp_reset to bit 0 of the written byte (1 holds the coprocessor in reset, 0 releases it). The other bits are ignored.
- R8: A coprocessor write with c_addr[3] = 1 uses c_addr[2:0] as an offset. Offset 0 drives cp_ack_n low and offset 1 drives it high. Offset 4 drives cp_stb_n low and offset 5 drives it high. Offsets 2, 3, 6 and 7 change nothing. A read in this window returns 0x00.
- R9: The interrupt enable register is read and written at c_addr 1. cp_irq is 1 exactly when enable bit 0 is 1 and cp_stb_n is 0. cp_irq_vec is 0x03 while cp_irq is 1 and 0x00 otherwise.
- R10: When both sides access in the same cycle, the coprocessor's effects apply first and the host's second. A host data write therefore wins the latch, and each flag and handshake line ends at the value the host access gives it.
- R11: Read data (h_rdata, c_rdata) is registered. It is valid on the cycle after the strobe and holds state from before that cycle's writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_cs | input | 1 | Host chip select |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | HADDR_W | Host I/O address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered |
| c_cs | input | 1 | Coprocessor chip select |
| c_rd | input | 1 | Coprocessor read strobe |
| c_wr | input | 1 | Coprocessor write strobe |
| c_addr | input | CP_AW | Coprocessor register address |
| c_wdata | input | 8 | Coprocessor write data |
| c_rdata | output | 8 | Coprocessor read data, registered |
| cp_ack_n | output | 1 | Input-side handshake line, active low |
| cp_stb_n | output | 1 | Output-side handshake line, active low |
| cp_irq | output | 1 | Gated interrupt request to the coprocessor |
| cp_irq_vec | output | 8 | Interrupt vector, 0x03 while cp_irq is high |
| cp_reset | output | 1 | Reset to the coprocessor |

## Verification
The bench builds the block with its default parameters: a 16-bit host address, so that random upper address bytes exercise the mirroring of both registers, and a 4-bit coprocessor address, which puts the latch, the enable register, the undecoded holes and all eight handshake offsets within reach of random stimulus. Random cycles often strobe both sides at once, which drives the same-cycle ordering rules of R10 across every pairing of reads and writes. Directed sequences cover the reset release, mirrored and unmapped host addresses, the ignored offsets, and a host write that collides with a coprocessor read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic rd_any;
        logic rd_stat;
        logic wr_ctrl;
        logic rd_data;
        logic wr_data;
    } host_op_t;

    typedef struct packed {
        logic rd_any;
        logic rd_latch;
        logic wr_latch;
        logic rd_ien;
        logic wr_ien;
        logic ack_clr;
        logic ack_set;
        logic stb_clr;
        logic stb_set;
    } cp_op_t;

    localparam logic [2:0] OFS_ACK_CLR = 3'd0;
    localparam logic [2:0] OFS_ACK_SET = 3'd1;
    localparam logic [2:0] OFS_STB_CLR = 3'd4;
    localparam logic [2:0] OFS_STB_SET = 3'd5;

    function automatic logic [BYTE_W-1:0] status_byte(input logic rx, input logic tx);
        return {4'hF, 2'b00, tx, rx};
    endfunction

endpackage

// File: rtl/mbx_host_dec.sv
module mbx_host_dec
    import mbx_pkg::*;
#(
    parameter int          HADDR_W   = 16,
    parameter logic [7:0]  STAT_ADDR = 8'hB8,
    parameter logic [7:0]  DATA_ADDR = 8'hB9
) (
    input  logic               cs,
    input  logic               rd,
    input  logic               wr,
    input  logic [HADDR_W-1:0] addr,
    output host_op_t           op
);
    logic [7:0] low_addr;
    logic       hit_stat;
    logic       hit_data;

    always_comb begin
        low_addr   = addr[7:0];
        hit_stat   = cs && (low_addr == STAT_ADDR);
        hit_data   = cs && (low_addr == DATA_ADDR);
        op.rd_any  = cs && rd;
        op.rd_stat = hit_stat && rd;
        op.wr_ctrl = hit_stat && wr;
        op.rd_data = hit_data && rd;
        op.wr_data = hit_data && wr;
    end
endmodule

// File: rtl/mbx_cp_dec.sv
module mbx_cp_dec
    import mbx_pkg::*;
#(
    parameter int CP_AW = 4
) (
    input  logic             cs,
    input  logic             rd,
    input  logic             wr,
    input  logic [CP_AW-1:0] addr,
    output cp_op_t           op
);
    localparam logic [CP_AW-1:0] LATCH_SEL = CP_AW'(0);
    localparam logic [CP_AW-1:0] IEN_SEL   = CP_AW'(1);

    logic       in_window;
    logic [2:0] ofs;
    logic       win_wr;

    always_comb begin
        in_window   = addr[CP_AW-1];
        ofs         = addr[2:0];
        win_wr      = cs && wr && in_window;
        op.rd_any   = cs && rd;
        op.rd_latch = cs && rd && (addr == LATCH_SEL);
        op.wr_latch = cs && wr && (addr == LATCH_SEL);
        op.rd_ien   = cs && rd && (addr == IEN_SEL);
        op.wr_ien   = cs && wr && (addr == IEN_SEL);
        op.ack_clr  = win_wr && (ofs == OFS_ACK_CLR);
        op.ack_set  = win_wr && (ofs == OFS_ACK_SET);
        op.stb_clr  = win_wr && (ofs == OFS_STB_CLR);
        op.stb_set  = win_wr && (ofs == OFS_STB_SET);
    end
endmodule

// File: rtl/mbx_core.sv
module mbx_core
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_op_t          hop,
    input  cp_op_t            cop,
    input  logic [BYTE_W-1:0] h_wdata,
    input  logic [BYTE_W-1:0] c_wdata,
    output logic [BYTE_W-1:0] h_rdata,
    output logic [BYTE_W-1:0] c_rdata,
    output logic [BYTE_W-1:0] ien,
    output logic              ack_n,
    output logic              stb_n,
    output logic              cp_reset
);
    logic [BYTE_W-1:0] latch_q;
    logic              rx_q;
    logic              tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q  <= '0;
            rx_q     <= 1'b0;
            tx_q     <= 1'b0;
            ien      <= '0;
            ack_n    <= 1'b1;
            stb_n    <= 1'b1;
            cp_reset <= 1'b1;
            h_rdata  <= '0;
            c_rdata  <= '0;
        end else begin
            // coprocessor effects first
            if (cop.wr_latch) begin
                latch_q <= c_wdata;
                rx_q    <= 1'b0;
            end
            if (cop.rd_latch) tx_q  <= 1'b0;
            if (cop.wr_ien)   ien   <= c_wdata;
            if (cop.ack_clr)  ack_n <= 1'b0;
            if (cop.ack_set)  ack_n <= 1'b1;
            if (cop.stb_clr)  stb_n <= 1'b0;
            if (cop.stb_set)  stb_n <= 1'b1;
            // host effects second, so they override
            if (hop.wr_data) begin
                latch_q <= h_wdata;
                tx_q    <= 1'b1;
                stb_n   <= 1'b0;
            end
            if (hop.rd_data) begin
                rx_q  <= 1'b1;
                ack_n <= 1'b0;
            end
            if (hop.wr_ctrl) cp_reset <= h_wdata[0];
            // registered read data from pre-update state
            if (hop.rd_stat)      h_rdata <= status_byte(rx_q, tx_q);
            else if (hop.rd_data) h_rdata <= latch_q;
            else if (hop.rd_any)  h_rdata <= '0;
            if (cop.rd_latch)     c_rdata <= latch_q;
            else if (cop.rd_ien)  c_rdata <= ien;
            else if (cop.rd_any)  c_rdata <= '0;
        end
    end
endmodule

// File: rtl/byte_mailbox_bridge.sv
module byte_mailbox_bridge
    import mbx_pkg::*;
#(
    parameter int          HADDR_W   = 16,
    parameter int          CP_AW     = 4,
    parameter logic [7:0]  STAT_ADDR = 8'hB8,
    parameter logic [7:0]  DATA_ADDR = 8'hB9,
    parameter logic [7:0]  IRQ_VEC   = 8'h03
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               h_cs,
    input  logic               h_rd,
    input  logic               h_wr,
    input  logic [HADDR_W-1:0] h_addr,
    input  logic [7:0]         h_wdata,
    output logic [7:0]         h_rdata,
    input  logic               c_cs,
    input  logic               c_rd,
    input  logic               c_wr,
    input  logic [CP_AW-1:0]   c_addr,
    input  logic [7:0]         c_wdata,
    output logic [7:0]         c_rdata,
    output logic               cp_ack_n,
    output logic               cp_stb_n,
    output logic               cp_irq,
    output logic [7:0]         cp_irq_vec,
    output logic               cp_reset
);
    host_op_t    hop;
    cp_op_t      cop;
    logic [7:0]  ien;

    mbx_host_dec #(
        .HADDR_W  (HADDR_W),
        .STAT_ADDR(STAT_ADDR),
        .DATA_ADDR(DATA_ADDR)
    ) u_hdec (
        .cs  (h_cs),
        .rd  (h_rd),
        .wr  (h_wr),
        .addr(h_addr),
        .op  (hop)
    );

    mbx_cp_dec #(
        .CP_AW(CP_AW)
    ) u_cdec (
        .cs  (c_cs),
        .rd  (c_rd),
        .wr  (c_wr),
        .addr(c_addr),
        .op  (cop)
    );

    mbx_core u_core (
        .clk     (clk),
        .rst     (rst),
        .hop     (hop),
        .cop     (cop),
        .h_wdata (h_wdata),
        .c_wdata (c_wdata),
        .h_rdata (h_rdata),
        .c_rdata (c_rdata),
        .ien     (ien),
        .ack_n   (cp_ack_n),
        .stb_n   (cp_stb_n),
        .cp_reset(cp_reset)
    );

    always_comb begin
        cp_irq     = ien[0] && !cp_stb_n;
        cp_irq_vec = cp_irq ? IRQ_VEC : 8'h00;
    end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int          HADDR_W   = 16,
    parameter int          CP_AW     = 4,
    parameter logic [7:0]  STAT_ADDR = 8'hB8,
    parameter logic [7:0]  DATA_ADDR = 8'hB9
) (
    input logic               clk,
    input logic               rst,
    input logic               h_cs,
    input logic               h_rd,
    input logic               h_wr,
    input logic [HADDR_W-1:0] h_addr,
    input logic [7:0]         h_wdata,
    input logic [7:0]         h_rdata,
    input logic               c_cs,
    input logic               c_wr,
    input logic [CP_AW-1:0]   c_addr,
    input logic               cp_ack_n,
    input logic               cp_stb_n,
    input logic               cp_irq,
    input logic               cp_reset
);
    logic h_stat, h_data, c_ack_set;
    always_comb begin
        h_stat    = h_cs && (h_addr[7:0] == STAT_ADDR);
        h_data    = h_cs && (h_addr[7:0] == DATA_ADDR);
        c_ack_set = c_cs && c_wr && c_addr[CP_AW-1] && (c_addr[2:0] == 3'd1);
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cp_reset && cp_ack_n && cp_stb_n && !cp_irq));

    // R3
    status_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        (h_stat && h_rd) |=> (h_rdata[7:2] == 6'b111100));

    // R4
    host_read_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (h_data && h_rd) |=> !cp_ack_n);

    // R5
    host_write_stb_chk: assert property (@(posedge clk) disable iff (rst)
        (h_data && h_wr) |=> !cp_stb_n);

    // R7
    reset_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (h_stat && h_wr) |=> (cp_reset == $past(h_wdata[0])));

    // R8
    ack_set_chk: assert property (@(posedge clk) disable iff (rst)
        (c_ack_set && !(h_data && h_rd)) |=> cp_ack_n);

    // R9
    irq_needs_stb_chk: assert property (@(posedge clk) disable iff (rst)
        cp_irq |-> !cp_stb_n);
endmodule

bind byte_mailbox_bridge mbx_checker #(
    .HADDR_W  (HADDR_W),
    .CP_AW    (CP_AW),
    .STAT_ADDR(STAT_ADDR),
    .DATA_ADDR(DATA_ADDR)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .h_cs    (h_cs),
    .h_rd    (h_rd),
    .h_wr    (h_wr),
    .h_addr  (h_addr),
    .h_wdata (h_wdata),
    .h_rdata (h_rdata),
    .c_cs    (c_cs),
    .c_wr    (c_wr),
    .c_addr  (c_addr),
    .cp_ack_n(cp_ack_n),
    .cp_stb_n(cp_stb_n),
    .cp_irq  (cp_irq),
    .cp_reset(cp_reset)
);

// File: tb/byte_mailbox_bridge_tb.sv
module byte_mailbox_bridge_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_cs = 0, h_rd = 0, h_wr = 0;
    logic [15:0] h_addr = '0;
    logic [7:0]  h_wdata = '0;
    logic [7:0]  h_rdata;
    logic        c_cs = 0, c_rd = 0, c_wr = 0;
    logic [3:0]  c_addr = '0;
    logic [7:0]  c_wdata = '0;
    logic [7:0]  c_rdata;
    logic        cp_ack_n, cp_stb_n, cp_irq, cp_reset;
    logic [7:0]  cp_irq_vec;

    int total = 0;
    int bad   = 0;

    // reference state
    logic [7:0] m_latch = 0, m_ien = 0, m_hr = 0, m_cr = 0;
    logic       m_rx = 0, m_tx = 0, m_ack = 1, m_stb = 1, m_rst = 1;
    logic       chk_hr = 0, chk_cr = 0;

    always #5 clk = ~clk;

    byte_mailbox_bridge u_dut (
        .clk(clk), .rst(rst),
        .h_cs(h_cs), .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata),
        .c_cs(c_cs), .c_rd(c_rd), .c_wr(c_wr), .c_addr(c_addr),
        .c_wdata(c_wdata), .c_rdata(c_rdata),
        .cp_ack_n(cp_ack_n), .cp_stb_n(cp_stb_n), .cp_irq(cp_irq),
        .cp_irq_vec(cp_irq_vec), .cp_reset(cp_reset)
    );

    function automatic logic [7:0] exp_status(input logic rx, input logic tx);
        return 8'hF0 | {6'd0, tx, rx};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        logic irq_e;
        irq_e = m_ien[0] && !m_stb;
        check({tag, " R7 cp_reset"}, {7'd0, cp_reset}, {7'd0, m_rst});
        check({tag, " R4/R8 ack"}, {7'd0, cp_ack_n}, {7'd0, m_ack});
        check({tag, " R5/R8 stb"}, {7'd0, cp_stb_n}, {7'd0, m_stb});
        check({tag, " R9 irq"}, {7'd0, cp_irq}, {7'd0, irq_e});
        check({tag, " R9 vec"}, cp_irq_vec, irq_e ? 8'h03 : 8'h00);
        if (chk_hr) check({tag, " R2/R3/R11 h_rdata"}, h_rdata, m_hr);
        if (chk_cr) check({tag, " R6/R9/R11 c_rdata"}, c_rdata, m_cr);
    endtask

    // one cycle: drive at negedge, update model, check at next negedge (R10 order)
    task automatic step(input string tag,
                        input logic hcs, input logic hrd, input logic hwr,
                        input logic [15:0] ha, input logic [7:0] hw,
                        input logic ccs, input logic crd, input logic cwr,
                        input logic [3:0] ca, input logic [7:0] cw);
        logic hs, hd;
        logic [7:0] old_latch, old_ien;
        logic old_rx, old_tx;
        h_cs = hcs; h_rd = hrd; h_wr = hwr; h_addr = ha; h_wdata = hw;
        c_cs = ccs; c_rd = crd; c_wr = cwr; c_addr = ca; c_wdata = cw;
        old_latch = m_latch; old_ien = m_ien; old_rx = m_rx; old_tx = m_tx;
        hs = hcs && (ha[7:0] == 8'hB8);
        hd = hcs && (ha[7:0] == 8'hB9);
        chk_hr = hcs && hrd;
        chk_cr = ccs && crd;
        // coprocessor side first
        if (ccs && cwr) begin
            if (ca == 4'd0) begin m_latch = cw; m_rx = 0; end
            if (ca == 4'd1) m_ien = cw;
            if (ca[3]) begin
                if (ca[2:0] == 3'd0) m_ack = 0;
                if (ca[2:0] == 3'd1) m_ack = 1;
                if (ca[2:0] == 3'd4) m_stb = 0;
                if (ca[2:0] == 3'd5) m_stb = 1;
            end
        end
        if (ccs && crd) begin
            if (ca == 4'd0)      begin m_cr = old_latch; m_tx = 0; end
            else if (ca == 4'd1) m_cr = old_ien;
            else                 m_cr = 8'h00;
        end
        // host side second
        if (hd && hwr) begin m_latch = hw; m_tx = 1; m_stb = 0; end
        if (hd && hrd) begin m_rx = 1; m_ack = 0; end
        if (hs && hwr) m_rst = hw[0];
        if (hcs && hrd) begin
            if (hs)      m_hr = exp_status(old_rx, old_tx);
            else if (hd) m_hr = old_latch;
            else         m_hr = 8'h00;
        end
        @(negedge clk);
        h_cs = 0; h_rd = 0; h_wr = 0; c_cs = 0; c_rd = 0; c_wr = 0;
        check_all(tag);
    endtask

    task automatic idle();
        step("idle", 0,0,0,16'h0,8'h0, 0,0,0,4'h0,8'h0);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1bad5eed);
        repeat (3) @(negedge clk);
        check_all("reset R1");
        rst = 0;
        // R1: reset values seen through the ports
        step("R1 status", 1,1,0,16'h00B8,8'h0, 1,1,0,4'h0,8'h0);
        step("R1 ien",    0,0,0,16'h0,8'h0,    1,1,0,4'h1,8'h0);
        // R7 release coprocessor reset, upper byte ignored (R2)
        step("R7 release", 1,0,1,16'h7FB8,8'hFE, 0,0,0,4'h0,8'h0);
        // R5 host write, R3 status shows tx
        step("R5 write",  1,0,1,16'h12B9,8'hA5, 0,0,0,4'h0,8'h0);
        step("R3 status", 1,1,0,16'hC3B8,8'h0,  0,0,0,4'h0,8'h0);
        // R9 enable irq, stb is low so irq rises
        step("R9 ien",    0,0,0,16'h0,8'h0,     1,0,1,4'h1,8'h01);
        idle();
        // R6 coprocessor read clears tx
        step("R6 cread",  0,0,0,16'h0,8'h0,     1,1,0,4'h0,8'h0);
        step("R6 status", 1,1,0,16'h00B8,8'h0,  0,0,0,4'h0,8'h0);
        // R8 ignored offsets, then set stb high
        step("R8 ofs2",   0,0,0,16'h0,8'h0,     1,0,1,4'hA,8'h0);
        step("R8 ofs6",   0,0,0,16'h0,8'h0,     1,0,1,4'hE,8'h0);
        step("R8 ofs3",   0,0,0,16'h0,8'h0,     1,0,1,4'hB,8'h0);
        step("R8 win rd", 0,0,0,16'h0,8'h0,     1,1,0,4'hD,8'h0);
        step("R8 stbset", 0,0,0,16'h0,8'h0,     1,0,1,4'hD,8'h0);
        // R6 coprocessor write, R4 host read
        step("R6 cwrite", 0,0,0,16'h0,8'h0,     1,0,1,4'h0,8'h3C);
        step("R4 hread",  1,1,0,16'hFFB9,8'h0,  0,0,0,4'h0,8'h0);
        step("R3 rx",     1,1,0,16'h00B8,8'h0,  0,0,0,4'h0,8'h0);
        // R2 unmapped host address
        step("R2 unmap",  1,1,1,16'h00BA,8'h77, 0,0,0,4'h0,8'h0);
        step("R2 after",  1,1,0,16'h00B9,8'h0,  0,0,0,4'h0,8'h0);
        // R10 collision: host write vs coprocessor read and write
        step("R10 a",     1,0,1,16'h00B9,8'h5A, 1,1,0,4'h0,8'h0);
        step("R10 b",     1,0,1,16'h00B9,8'hC7, 1,0,1,4'h0,8'h11);
        step("R10 c",     1,1,0,16'h00B9,8'h0,  1,0,1,4'h8,8'h0);
        step("R10 st",    1,1,0,16'h00B8,8'h0,  0,0,0,4'h0,8'h0);
        // random mix
        for (int i = 0; i < 1500; i++) begin
            logic [15:0] ha;
            logic [1:0]  pick;
            pick = 2'($urandom % 4);
            ha[15:8] = 8'($urandom);
            case (pick)
                2'd0:    ha[7:0] = 8'hB8;
                2'd3:    ha[7:0] = 8'($urandom);
                default: ha[7:0] = 8'hB9;
            endcase
            step("rand R10",
                 1'($urandom), 1'($urandom), 1'($urandom), ha, 8'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule